// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Read Path

This block is the load side of a small level-1 cache. The cache holds 4 KiB in 64-byte lines, which gives 64 lines arranged as 32 sets of two ways. The cache is indexed and tagged with the same 32-bit address the requester presents.

Each accepted request does one array access. That access reads the pair of tags and the pair of candidate 32-bit words for the addressed set at the same time. Both tags are compared with the request, and a late multiplexer steers out the word of the way that matches. The tag array has 32 rows, and each row holds both 21-bit tags of one set. The data array has 512 rows of 8 bytes, and each row holds the word at one offset for both ways.

On a hit the word appears one cycle after acceptance. On a miss the block reports the miss and then fetches the line as 16 words over a request/return port. It writes the line into the least recently used way of the set, then looks the address up again and reports the word as a hit.

Top module: `dual_way_read_cache`

## Requirements
- R1: The address is split as follows: tag = bits 31:11, set = bits 10:6, word within line = bits 5:2. Bits 1:0 have no effect on the result, so two addresses that differ only there return the same word.
- R2: After reset every way of every set is invalid, so the first access to any address is a miss.
- R3: A hit is reported in the cycle after the request is accepted, with `rsp_valid`=1, `rsp_hit`=1 and `rsp_data` equal to the stored word. This holds for every word position of a line, including the last one.
- R4: A miss is reported in the cycle after acceptance with `rsp_valid`=1, `rsp_hit`=0 and `rsp_data`=0. It is followed by `mem_req_valid` with `mem_req_addr` = {tag, set, 6'b0}, and the block holds both steady until `mem_req_ready`.
- R5: The refill takes exactly 16 beats while `mem_rready` is high, and beat k carries word k of the line. Gaps in `mem_rvalid` are tolerated. The block then reports the requested word with `rsp_hit`=1. No new request is accepted between the miss report and that response.
- R6: Two lines with the same set and different tags can both be resident and both hit.
- R7: A miss replaces the way of the set that was used least recently, where both hits and refills count as uses. The line that was used more recently stays resident.
- R8: A refill changes only the set it addresses. Lines already resident in other sets still hit.
- R9: A new request is accepted in the same cycle as a hit response, so hits can be issued back to back, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Result came from a matching valid way |
| rsp_data | output | 32 | Word read; zero on a miss report |
| mem_req_valid | output | 1 | Line fetch request |
| mem_req_ready | input | 1 | Memory takes the line fetch |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_rvalid | input | 1 | Refill word present |
| mem_rready | output | 1 | Block is collecting refill words |
| mem_rdata | input | 32 | Refill word, in ascending order |

## Verification
Some internal faults are visible on the very next lookup of the affected set. A corrupted tag, valid bit or data row shows up there as a wrong hit flag or a wrong word. A fault in the recency bit stays hidden until the third distinct tag arrives in a set. At that point the wrong line is evicted, and the error shows one access later, when the line that should still be resident misses. Errors in the beat counter or the row address of refill writes appear as wrong words on later hits to other offsets of the same line. For that reason, first and last offsets are read back after each fill.

// File: rtl/dwrc_pkg.sv
package dwrc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOK,
      ST_MREQ,
      ST_FILL,
      ST_RETRY
   } dwrc_state_e;

endpackage

// File: rtl/dwrc_tag_array.sv
module dwrc_tag_array #(
   parameter int SETS  = 32,
   parameter int TAG_W = 21,
   parameter int WAYS  = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                       clk,
   input  logic                       rd_en,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
   input  logic                       wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [WAY_W-1:0]           wr_way,
   input  logic [TAG_W-1:0]           wr_tag
);

   logic [WAYS-1:0][TAG_W-1:0] rows [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) rows[wr_idx][wr_way] <= wr_tag;
      if (rd_en) rd_tags <= rows[rd_idx];
   end

endmodule

// File: rtl/dwrc_data_array.sv
module dwrc_data_array #(
   parameter int ROWS   = 512,
   parameter int WORD_W = 32,
   parameter int WAYS   = 2,
   localparam int ROW_W = $clog2(ROWS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rd_en,
   input  logic [ROW_W-1:0]            rd_row,
   output logic [WAYS-1:0][WORD_W-1:0] rd_words,
   input  logic                        wr_en,
   input  logic [ROW_W-1:0]            wr_row,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [WORD_W-1:0]           wr_word
);

   logic [WAYS-1:0][WORD_W-1:0] rows [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) rows[wr_row][wr_way] <= wr_word;
      if (rd_en) rd_words <= rows[rd_row];
   end

endmodule

// File: rtl/dwrc_way_pick.sv
module dwrc_way_pick #(
   parameter int TAG_W  = 21,
   parameter int WORD_W = 32,
   parameter int WAYS   = 2,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [TAG_W-1:0]            look_tag,
   input  logic [WAYS-1:0][TAG_W-1:0]  tags,
   input  logic [WAYS-1:0]             vld,
   input  logic [WAYS-1:0][WORD_W-1:0] words,
   output logic                        hit,
   output logic [WAY_W-1:0]            hit_way,
   output logic [WORD_W-1:0]           word
);

   logic [WAYS-1:0] match;

   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign match[g] = vld[g] && (tags[g] == look_tag);
   end

   // lowest numbered matching way wins
   always_comb begin
      hit_way = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

   assign hit  = |match;
   assign word = words[hit_way];

endmodule

// File: rtl/dwrc_set_state.sv
module dwrc_set_state #(
   parameter int SETS = 32,
   parameter int WAYS = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] look_idx,
   output logic [WAYS-1:0]  vld_out,
   output logic [WAY_W-1:0] victim_out,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   input  logic [WAY_W-1:0] touch_way,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [WAY_W-1:0] fill_way
);

   logic [SETS-1:0][WAYS-1:0]  vld_q;
   logic [SETS-1:0][WAY_W-1:0] lru_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         lru_q <= '0;
      end else begin
         if (fill_en)  vld_q[fill_idx][fill_way] <= 1'b1;
         if (touch_en) lru_q[touch_idx] <= ~touch_way;
      end
   end

   assign vld_out    = vld_q[look_idx];
   assign victim_out = lru_q[look_idx];

endmodule

// File: rtl/dual_way_read_cache.sv
module dual_way_read_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int SETS       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [WORD_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rvalid,
   output logic              mem_rready,
   input  logic [WORD_W-1:0] mem_rdata
);
   import dwrc_pkg::*;

   localparam int WAYS       = 2;
   localparam int WAY_W      = $clog2(WAYS);
   localparam int WBYTES     = WORD_W / 8;
   localparam int BYTE_OFF_W = $clog2(WBYTES);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int WSEL_W     = OFF_W - BYTE_OFF_W;
   localparam int WORDS      = LINE_BYTES / WBYTES;
   localparam int IDX_W      = $clog2(SETS);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int ROWS       = SETS * WORDS;
   localparam int ROW_W      = IDX_W + WSEL_W;
   localparam int KEEP_W     = ADDR_W - BYTE_OFF_W;

   if ((1 << IDX_W) != SETS || (1 << OFF_W) != LINE_BYTES ||
       WORD_W % 8 != 0 || WORDS < 2 || TAG_W < 1) begin : g_bad_cfg
      $error("dual_way_read_cache: unsupported geometry");
   end

   dwrc_state_e st_q;
   logic [KEEP_W-1:0] addr_q;
   logic [WAY_W-1:0]  vict_q;
   logic [WSEL_W-1:0] beat_q;

   logic unused_byte_bits;
   assign unused_byte_bits = ^req_addr[BYTE_OFF_W-1:0];

   logic [TAG_W-1:0]  f_tag;
   logic [IDX_W-1:0]  f_idx;
   assign f_tag = addr_q[KEEP_W-1 -: TAG_W];
   assign f_idx = addr_q[WSEL_W +: IDX_W];

   logic accept, rd_en, look, look_hit, beat, last_beat;
   logic [IDX_W-1:0] rd_idx;
   logic [ROW_W-1:0] rd_row;

   logic [WAYS-1:0][TAG_W-1:0]  tags_rd;
   logic [WAYS-1:0][WORD_W-1:0] words_rd;
   logic [WAYS-1:0]             vld_rd;
   logic [WAY_W-1:0]            victim;
   logic                        pick_hit;
   logic [WAY_W-1:0]            pick_way;
   logic [WORD_W-1:0]           pick_word;

   assign look      = (st_q == ST_LOOK);
   assign look_hit  = look && pick_hit;
   assign req_ready = (st_q == ST_IDLE) || look_hit;
   assign accept    = req_valid && req_ready;
   assign beat      = (st_q == ST_FILL) && mem_rvalid;
   assign last_beat = beat && (beat_q == WSEL_W'(WORDS - 1));

   assign rd_en  = accept || (st_q == ST_RETRY);
   assign rd_idx = accept ? req_addr[OFF_W +: IDX_W] : f_idx;
   assign rd_row = accept ? req_addr[BYTE_OFF_W +: ROW_W] : addr_q[ROW_W-1:0];

   dwrc_tag_array #(.SETS(SETS), .TAG_W(TAG_W), .WAYS(WAYS)) u_tags (
      .clk     (clk),
      .rd_en   (rd_en),
      .rd_idx  (rd_idx),
      .rd_tags (tags_rd),
      .wr_en   (last_beat),
      .wr_idx  (f_idx),
      .wr_way  (vict_q),
      .wr_tag  (f_tag)
   );

   dwrc_data_array #(.ROWS(ROWS), .WORD_W(WORD_W), .WAYS(WAYS)) u_data (
      .clk      (clk),
      .rd_en    (rd_en),
      .rd_row   (rd_row),
      .rd_words (words_rd),
      .wr_en    (beat),
      .wr_row   ({f_idx, beat_q}),
      .wr_way   (vict_q),
      .wr_word  (mem_rdata)
   );

   dwrc_set_state #(.SETS(SETS), .WAYS(WAYS)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_idx   (f_idx),
      .vld_out    (vld_rd),
      .victim_out (victim),
      .touch_en   (look_hit || last_beat),
      .touch_idx  (f_idx),
      .touch_way  (look_hit ? pick_way : vict_q),
      .fill_en    (last_beat),
      .fill_idx   (f_idx),
      .fill_way   (vict_q)
   );

   dwrc_way_pick #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WAYS(WAYS)) u_pick (
      .look_tag (f_tag),
      .tags     (tags_rd),
      .vld      (vld_rd),
      .words    (words_rd),
      .hit      (pick_hit),
      .hit_way  (pick_way),
      .word     (pick_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         addr_q <= '0;
         vict_q <= '0;
         beat_q <= '0;
      end else begin
         if (accept) addr_q <= req_addr[ADDR_W-1:BYTE_OFF_W];
         unique case (st_q)
            ST_IDLE:  if (accept) st_q <= ST_LOOK;
            ST_LOOK: begin
               if (pick_hit) begin
                  st_q <= accept ? ST_LOOK : ST_IDLE;
               end else begin
                  st_q   <= ST_MREQ;
                  vict_q <= victim;
               end
            end
            ST_MREQ: begin
               beat_q <= '0;
               if (mem_req_ready) st_q <= ST_FILL;
            end
            ST_FILL: begin
               if (beat) beat_q <= beat_q + 1'b1;
               if (last_beat) st_q <= ST_RETRY;
            end
            ST_RETRY: st_q <= ST_LOOK;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid     = look;
   assign rsp_hit       = look_hit;
   assign rsp_data      = look_hit ? pick_word : '0;
   assign mem_req_valid = (st_q == ST_MREQ);
   assign mem_req_addr  = {f_tag, f_idx, {OFF_W{1'b0}}};
   assign mem_rready    = (st_q == ST_FILL);

endmodule

// File: rtl/dwrc_chk.sv
module dwrc_chk #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int OFF_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [WORD_W-1:0] rsp_data,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rready
);

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid); // R3

   AST_MISS_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_data == '0)); // R4

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R4

   AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4

   AST_MISS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> !req_ready); // R5

   AST_FILL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rready |-> (!req_ready && !rsp_valid && !mem_req_valid)); // R5

endmodule

bind dual_way_read_cache dwrc_chk #(
   .ADDR_W (ADDR_W),
   .WORD_W (WORD_W),
   .OFF_W  (OFF_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .rsp_hit       (rsp_hit),
   .rsp_data      (rsp_data),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_rready    (mem_rready)
);

// File: tb/dual_way_read_cache_tb.sv
`timescale 1ns/1ps
module dual_way_read_cache_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [31:0] rsp_data;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_req_addr;
   logic        mem_rvalid = 1'b0;
   logic        mem_rready;
   logic [31:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_way_read_cache u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_data (rsp_data),
      .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
      .mem_req_addr (mem_req_addr), .mem_rvalid (mem_rvalid),
      .mem_rready (mem_rready), .mem_rdata (mem_rdata)
   );

   typedef struct packed {
      logic        hit;
      logic [31:0] addr;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 32'h0000_08D4, 4'd2},  // R2 cold miss, set 3 tag 1
      '{1'b1, 32'h0000_08D4, 4'd3},  // R3 same word hits
      '{1'b1, 32'h0000_08D7, 4'd1},  // R1 byte bits ignored
      '{1'b1, 32'h0000_08FC, 4'd3},  // R3 last word of line
      '{1'b0, 32'h0000_10C0, 4'd6},  // R6 second tag in set 3
      '{1'b1, 32'h0000_08C0, 4'd6},  // R6 first tag still there
      '{1'b0, 32'h0000_18DC, 4'd7},  // R7 third tag evicts tag 2
      '{1'b1, 32'h0000_08D4, 4'd7},  // R7 tag 1 kept
      '{1'b1, 32'h0000_18DC, 4'd7},  // R7 tag 3 resident
      '{1'b0, 32'h0000_10C0, 4'd7},  // R7 tag 2 gone, evicts tag 1
      '{1'b1, 32'h0000_18DC, 4'd7},  // R7 tag 3 kept
      '{1'b0, 32'h0000_08C0, 4'd7},  // R7 tag 1 gone, evicts tag 2
      '{1'b1, 32'h0000_18DC, 4'd7},  // R7
      '{1'b0, 32'h0000_1104, 4'd8},  // R8 set 4 fill
      '{1'b1, 32'h0000_1104, 4'd8},  // R8
      '{1'b1, 32'h0000_08C0, 4'd8},  // R8 set 3 untouched
      '{1'b0, 32'hFFFF_FFFC, 4'd5},  // R5 top set, top tag
      '{1'b1, 32'hFFFF_FFC0, 4'd3},  // R3 first word of that line
      '{1'b0, 32'h0000_0000, 4'd5},  // R5 set 0 tag 0
      '{1'b1, 32'h0000_003C, 4'd3}   // R3
   };

   function automatic logic [31:0] mw(input logic [31:0] a);
      return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic do_access(input logic [31:0] a, input bit exp_hit, input string rq);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      chk(rsp_valid == 1'b1, rq, 32'(rsp_valid), 32'd1);
      chk(rsp_hit == exp_hit, rq, 32'(rsp_hit), 32'(exp_hit));
      req_valid = 1'b0;
      if (exp_hit) begin
         chk(rsp_data == mw(a), rq, rsp_data, mw(a));
      end else begin
         chk(rsp_data == 32'h0, "R4 miss data", rsp_data, 32'h0);
         chk(req_ready == 1'b0, "R5 blocked", 32'(req_ready), 32'd0);
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == {a[31:6], 6'b0}, "R4 fetch",
             mem_req_addr, {a[31:6], 6'b0});
         @(negedge clk);
         chk(mem_req_valid && mem_req_addr == {a[31:6], 6'b0}, "R4 held",
             mem_req_addr, {a[31:6], 6'b0});
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         for (int k = 0; k < 16; k++) begin
            if (k == 5) begin
               mem_rvalid = 1'b0;
               @(negedge clk);
            end
            chk(mem_rready == 1'b1, "R5 rready", 32'(mem_rready), 32'd1);
            mem_rvalid = 1'b1;
            mem_rdata  = mw({a[31:6], 4'(k), 2'b00});
            @(negedge clk);
         end
         mem_rvalid = 1'b0;
         for (int n = 0; n < 8 && !rsp_valid; n++) @(negedge clk);
         chk(rsp_valid && rsp_hit, "R5 replay hit", 32'(rsp_hit), 32'd1);
         chk(rsp_data == mw(a), "R5 replay data", rsp_data, mw(a));
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R5 actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2 reset state at the ports
      chk(req_ready == 1'b1, "R2 ready", 32'(req_ready), 32'd1);
      chk(!rsp_valid && !mem_req_valid && !mem_rready, "R2 idle outputs",
          {29'd0, rsp_valid, mem_req_valid, mem_rready}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         do_access(VEC[i].addr, VEC[i].hit, $sformatf("R%0d vec%0d", VEC[i].rq, i));
      end

      // R9 back-to-back hits on resident tags 1 and 3 of set 3
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 32'h0000_08C0;
      @(negedge clk);
      chk(rsp_valid && rsp_hit && rsp_data == mw(32'h08C0), "R9 first",
          rsp_data, mw(32'h08C0));
      chk(req_ready == 1'b1, "R9 ready with hit", 32'(req_ready), 32'd1);
      req_addr = 32'h0000_18DC;
      @(negedge clk);
      chk(rsp_valid && rsp_hit && rsp_data == mw(32'h18DC), "R9 second",
          rsp_data, mw(32'h18DC));
      req_valid = 1'b0;

      // R2 reset mid-run clears all lines
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      do_access(32'h0000_08C0, 1'b0, "R2 after reset");
      do_access(32'h0000_08C2, 1'b1, "R1 byte bits");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule